// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter with Idle and Break Generation

This block turns a parallel data word into an asynchronous serial frame on one output line. A data frame has three parts: a low start bit, then 8 or 9 data bits with the least significant bit first, then a high stop bit. When parity is enabled, the most significant data position carries an even or odd parity bit in place of the data bit. The parity covers the data bits below that position.

The block can also send two special frames on request. An idle frame holds the line high for one whole frame period and has no start bit. A break frame holds the line low for one whole frame period and then adds one extra high bit. A data word that is requested together with a special frame is held back and starts directly after the special frame ends.

The bit timing comes from a dedicated tick generator. Its division is set by a baud divider, or by an extended prescaler whenever the prescaler is nonzero. Each bit lasts 16 ticks. The block reports `busy` while a frame is on the line and gives a single-cycle `done` pulse when each frame ends.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0 and `done` is 0.
- R2: With `cfg_nine`=0 and parity off, a data frame is 10 bit periods: one 0 bit, then `tx_data[7:0]` LSB first, then one 1 bit.
- R3: With `cfg_nine`=1, a data frame is 11 bit periods, with `tx_data[8:0]` sent LSB first between the 0 start bit and the 1 stop bit.
- R4: With `cfg_par_en`=1, the bit at data position 7 (8-bit mode) or 8 (9-bit mode) is replaced by parity over the data bits below it. That parity is the XOR of those bits, inverted when `cfg_par_odd`=1.
- R5: A pulse on `idle_req` sends an idle frame: the line stays 1 for 10 bit periods (8-bit mode) or 11 bit periods (9-bit mode), with no start bit.
- R6: A pulse on `brk_req` sends a break frame: the line stays 0 for 10 or 11 bit periods, then 1 for one extra bit period.
- R7: When `brk_req` and `idle_req` are both high in the accepting cycle, a break frame is sent.
- R8: When `tx_req` is high together with `idle_req` or `brk_req`, the data frame's start bit begins in the first cycle after the special frame ends, and `busy` stays high between the two frames.
- R9: One bit period lasts 16*(N+1) clock cycles. N is `cfg_prescale` when that value is nonzero; otherwise N is `cfg_div`.
- R10: Requests are taken only while `busy` is 0. A request made during a frame changes neither that frame nor the line after it.
- R11: `done` goes high for exactly one cycle, the cycle right after the last bit period of each frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Baud divider, used when the prescaler is zero |
| cfg_prescale | input | PRE_W | Extended prescaler; when nonzero it sets the division |
| cfg_nine | input | 1 | Word length: 0 for 8 data bits, 1 for 9 data bits |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_odd | input | 1 | Parity mode: 0 for even, 1 for odd |
| tx_data | input | 9 | Data word to send |
| tx_req | input | 1 | Data frame request |
| idle_req | input | 1 | Idle frame request |
| brk_req | input | 1 | Break frame request |
| txd | output | 1 | Serial output line |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse when a frame ends |

## Verification
Several properties are checked on every cycle. The start bit is low and the stop bit is high. Break wins over idle. An idle frame never drives the line low. The shift state holds still between baud ticks, `done` never lasts two cycles, and a queued data word starts right after a special frame. Other behaviour shows only in the bench's scenarios, because it depends on the whole bit sequence and on timing. This covers the bit order, the value and position of the parity bit, the exact bit period for each divider setting, the length of idle and break frames, and the fact that requests made during a frame leave no trace.

// File: rtl/uftx_pkg.sv
package uftx_pkg;

  localparam int FRAME_W = 12;
  localparam int LIM_MAX = 16;

  typedef enum logic [1:0] {
    FR_DATA = 2'd0,
    FR_IDLE = 2'd1,
    FR_BRK  = 2'd2
  } frame_kind_e;

  // Division value: the prescaler overrides the divider when nonzero.
  function automatic logic [LIM_MAX-1:0] pick_limit(input logic [LIM_MAX-1:0] div,
                                                    input logic [LIM_MAX-1:0] pre);
    return (pre != '0) ? pre : div;
  endfunction

  // Put parity at the top data position, taken over the bits below it.
  function automatic logic [8:0] with_parity(input logic [8:0] d, input logic nine,
                                             input logic pe, input logic po);
    logic [8:0] r;
    logic       p;
    int         top;
    r   = d;
    p   = po;
    top = nine ? 8 : 7;
    for (int i = 0; i < 8; i++)
      if (i < top) p = p ^ d[i];
    if (pe) r[top] = p;
    return r;
  endfunction

  // Number of bit periods in a frame.
  function automatic logic [3:0] frame_len(input frame_kind_e k, input logic nine);
    logic [3:0] n;
    n = nine ? 4'd11 : 4'd10;
    if (k == FR_BRK) n = n + 4'd1;
    return n;
  endfunction

  // Line pattern, bit 0 is sent first.
  function automatic logic [FRAME_W-1:0] frame_bits(input frame_kind_e k,
                                                    input logic [8:0] d,
                                                    input logic nine);
    logic [FRAME_W-1:0] f;
    case (k)
      FR_IDLE: f = '1;
      FR_BRK: begin
        f = '0;
        if (nine) f[11] = 1'b1;
        else      f[10] = 1'b1;
      end
      default: begin
        f    = '1;
        f[0] = 1'b0;
        for (int i = 0; i < 9; i++)
          if (i < 8 || nine) f[i+1] = d[i];
      end
    endcase
    return f;
  endfunction

endpackage

// File: rtl/uftx_baud.sv
module uftx_baud #(
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [LIM_W-1:0] lim,
  output logic             tick
);

  logic [LIM_W-1:0] cnt_q;

  assign tick = en && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!en)    cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R9: the counter never passes the chosen division while the divisor is held
  assert_cnt_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $stable(lim)) |-> (cnt_q <= lim));

endmodule

// File: rtl/uftx_seq.sv
module uftx_seq
  import uftx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       nine_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic [8:0] tx_data_i,
  input  logic       tx_req_i,
  input  logic       idle_req_i,
  input  logic       brk_req_i,
  output logic       txd_o,
  output logic       run_o,
  output logic       done_o
);

  localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  logic                run_q;
  frame_kind_e         kind_q;
  logic [FRAME_W-1:0]  sh_q;
  logic [3:0]          left_q;
  logic [SUB_W-1:0]    sub_q;
  logic                pend_q;
  logic [8:0]          pend_d_q;
  logic                done_q;

  // Named events
  logic        ev_accept;
  logic        ev_bit_end;
  logic        ev_frame_end;
  frame_kind_e acc_kind;
  logic [8:0]  acc_word;
  logic [8:0]  pend_word;

  assign ev_accept    = !run_q && (tx_req_i || idle_req_i || brk_req_i);
  assign ev_bit_end   = run_q && tick_i && (sub_q == SUB_LAST);
  assign ev_frame_end = ev_bit_end && (left_q == 4'd1);

  always_comb begin
    if (brk_req_i)       acc_kind = FR_BRK;
    else if (idle_req_i) acc_kind = FR_IDLE;
    else                 acc_kind = FR_DATA;
  end

  assign acc_word  = with_parity(tx_data_i, nine_i, par_en_i, par_odd_i);
  assign pend_word = with_parity(pend_d_q,  nine_i, par_en_i, par_odd_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      kind_q   <= FR_IDLE;
      sh_q     <= '1;
      left_q   <= '0;
      sub_q    <= '0;
      pend_q   <= 1'b0;
      pend_d_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= ev_frame_end;
      if (ev_accept) begin
        run_q    <= 1'b1;
        kind_q   <= acc_kind;
        sh_q     <= frame_bits(acc_kind, acc_word, nine_i);
        left_q   <= frame_len(acc_kind, nine_i);
        sub_q    <= '0;
        pend_q   <= tx_req_i && (acc_kind != FR_DATA);
        pend_d_q <= tx_data_i;
      end else if (run_q && tick_i) begin
        if (sub_q == SUB_LAST) begin
          sub_q <= '0;
          if (left_q == 4'd1) begin
            if (pend_q) begin
              kind_q <= FR_DATA;
              sh_q   <= frame_bits(FR_DATA, pend_word, nine_i);
              left_q <= frame_len(FR_DATA, nine_i);
              pend_q <= 1'b0;
            end else begin
              run_q  <= 1'b0;
              sh_q   <= '1;
              left_q <= '0;
            end
          end else begin
            sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
            left_q <= left_q - 4'd1;
          end
        end else begin
          sub_q <= sub_q + 1'b1;
        end
      end
    end
  end

  assign txd_o  = run_q ? sh_q[0] : 1'b1;
  assign run_o  = run_q;
  assign done_o = done_q;

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_brk_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && brk_req_i) |=> (kind_q == FR_BRK));

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_accept && acc_kind == FR_DATA) |=> !txd_o);

  assert_stop_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_frame_end && kind_q == FR_DATA) |-> txd_o);

  assert_idle_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && kind_q == FR_IDLE) |-> txd_o);

  assert_hold_between_ticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick_i) |=> ($stable(sh_q) && $stable(left_q)));

  assert_pend_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_frame_end && pend_q) |=> (run_q && kind_q == FR_DATA && !txd_o));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uftx_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int PRE_W = 8,
  parameter int OVS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [PRE_W-1:0] cfg_prescale,
  input  logic             cfg_nine,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic [8:0]       tx_data,
  input  logic             tx_req,
  input  logic             idle_req,
  input  logic             brk_req,
  output logic             txd,
  output logic             busy,
  output logic             done
);

  localparam int LIM_W = (DIV_W > PRE_W) ? DIV_W : PRE_W;

  logic [LIM_MAX-1:0] lim_full;
  logic [LIM_W-1:0]   lim;
  logic               run;
  logic               tick;

  assign lim_full = pick_limit(LIM_MAX'(cfg_div), LIM_MAX'(cfg_prescale));
  assign lim      = lim_full[LIM_W-1:0];

  uftx_baud #(.LIM_W(LIM_W)) u_baud (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (run),
    .lim  (lim),
    .tick (tick)
  );

  uftx_seq #(.OVS(OVS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .nine_i    (cfg_nine),
    .par_en_i  (cfg_par_en),
    .par_odd_i (cfg_par_odd),
    .tx_data_i (tx_data),
    .tx_req_i  (tx_req),
    .idle_req_i(idle_req),
    .brk_req_i (brk_req),
    .txd_o     (txd),
    .run_o     (run),
    .done_o    (done)
  );

  assign busy = run;

endmodule

// File: tb/uart_frame_tx_tb.sv
module uart_frame_tx_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_div = 8'd1;
  logic [7:0] cfg_prescale = 8'd0;
  logic       cfg_nine = 1'b0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic [8:0] tx_data = '0;
  logic       tx_req = 1'b0;
  logic       idle_req = 1'b0;
  logic       brk_req = 1'b0;
  logic       txd, busy, done;

  int checks = 0;
  int fails = 0;
  int pos = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  uart_frame_tx u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_prescale(cfg_prescale),
    .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .tx_data(tx_data), .tx_req(tx_req), .idle_req(idle_req), .brk_req(brk_req),
    .txd(txd), .busy(busy), .done(done)
  );

  // {data[8:0], nine, par_en, par_odd}
  localparam logic [11:0] VEC [7] = '{
    {9'h0A5, 1'b0, 1'b0, 1'b0},
    {9'h101, 1'b0, 1'b0, 1'b0},
    {9'h15A, 1'b1, 1'b0, 1'b0},
    {9'h03C, 1'b0, 1'b1, 1'b0},
    {9'h03C, 1'b0, 1'b1, 1'b1},
    {9'h1FF, 1'b1, 1'b1, 1'b0},
    {9'h0FE, 1'b1, 1'b1, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_to(input int p);
    while (pos < p) begin
      @(negedge clk);
      pos++;
    end
  endtask

  function automatic int bit_period();
    int n;
    n = (cfg_prescale != 0) ? int'(cfg_prescale) : int'(cfg_div);
    return 16 * (n + 1);
  endfunction

  task automatic exp_data(input logic [8:0] d, output logic [15:0] f, output int len);
    int nd, ones;
    logic [8:0] w;
    nd = cfg_nine ? 9 : 8;
    w = d;
    if (cfg_par_en) begin
      ones = 0;
      for (int i = 0; i < nd - 1; i++) ones += int'(d[i]);
      w[nd-1] = ((ones % 2) == 1) ^ cfg_par_odd;
    end
    f = '1;
    for (int b = 0; b < nd + 2; b++) begin
      if (b == 0)       f[b] = 1'b0;
      else if (b <= nd) f[b] = w[b-1];
      else              f[b] = 1'b1;
    end
    len = nd + 2;
  endtask

  task automatic send(input bit dr, input bit ir, input bit br, input logic [8:0] d);
    @(negedge clk);
    tx_data = d; tx_req = dr; idle_req = ir; brk_req = br;
    @(negedge clk);
    tx_req = 1'b0; idle_req = 1'b0; brk_req = 1'b0;
    pos = 0;
  endtask

  task automatic check_frame(input logic [15:0] f, input int len, input int bp,
                             input string req, input bit more);
    for (int b = 0; b < len; b++) begin
      int t;
      t = b * bp + bp / 2;
      if (t >= pos) begin
        wait_to(t);
        chk(txd === f[b], req, $sformatf("bit %0d", b), int'(txd), int'(f[b]));
      end
    end
    wait_to(len * bp - 1);
    chk(done === 1'b0 && busy === 1'b1, "R11", "before frame end done/busy",
        int'({done, busy}), 1);
    wait_to(len * bp);
    chk(done === 1'b1, "R11", "done at frame end", int'(done), 1);
    if (!more) begin
      chk(busy === 1'b0 && txd === 1'b1, req, "line free after frame",
          int'({busy, txd}), 1);
      wait_to(len * bp + 1);
      chk(done === 1'b0, "R11", "done lasts one cycle", int'(done), 0);
    end else begin
      chk(busy === 1'b1 && txd === 1'b0, "R8", "queued start bit follows",
          int'({busy, txd}), 2);
      pos = pos - len * bp;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] f;
    int len, bp;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(txd === 1'b1 && busy === 1'b0 && done === 1'b0, "R1", "in reset",
        int'({txd, busy, done}), 4);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(txd === 1'b1 && busy === 1'b0 && done === 1'b0, "R1", "after reset",
        int'({txd, busy, done}), 4);

    // Vector table: R2 / R3 / R4
    for (int v = 0; v < 7; v++) begin
      logic [8:0] d;
      string tag;
      {d, cfg_nine, cfg_par_en, cfg_par_odd} = VEC[v];
      tag = cfg_par_en ? "R4" : (cfg_nine ? "R3" : "R2");
      bp = bit_period();
      exp_data(d, f, len);
      send(1'b1, 1'b0, 1'b0, d);
      check_frame(f, len, bp, tag, 1'b0);
    end

    cfg_par_en = 1'b0; cfg_par_odd = 1'b0;

    // R5: idle frame in both word lengths
    for (int m = 0; m < 2; m++) begin
      cfg_nine = m[0];
      bp = bit_period();
      send(1'b0, 1'b1, 1'b0, 9'h000);
      check_frame(16'hFFFF, 10 + m, bp, "R5", 1'b0);
    end

    // R6: break frame, zeros then one extra high bit
    for (int m = 0; m < 2; m++) begin
      cfg_nine = m[0];
      bp = bit_period();
      f = '0;
      f[10 + m] = 1'b1;
      send(1'b0, 1'b0, 1'b1, 9'h000);
      check_frame(f, 11 + m, bp, "R6", 1'b0);
    end

    // R7: break wins over idle
    cfg_nine = 1'b0;
    bp = bit_period();
    f = '0; f[10] = 1'b1;
    send(1'b0, 1'b1, 1'b1, 9'h000);
    check_frame(f, 11, bp, "R7", 1'b0);

    // R8: data queued behind idle, then behind break
    send(1'b1, 1'b1, 1'b0, 9'h0C3);
    check_frame(16'hFFFF, 10, bp, "R8", 1'b1);
    exp_data(9'h0C3, f, len);
    check_frame(f, len, bp, "R8", 1'b0);

    send(1'b1, 1'b0, 1'b1, 9'h01E);
    f = '0; f[10] = 1'b1;
    check_frame(f, 11, bp, "R8", 1'b1);
    exp_data(9'h01E, f, len);
    check_frame(f, len, bp, "R8", 1'b0);

    // R9: prescaler overrides divider, then divider alone
    cfg_div = 8'd1; cfg_prescale = 8'd3;
    bp = bit_period();
    chk(bp == 64, "R9", "bench period with prescaler", bp, 64);
    exp_data(9'h069, f, len);
    send(1'b1, 1'b0, 1'b0, 9'h069);
    check_frame(f, len, bp, "R9", 1'b0);

    cfg_div = 8'd2; cfg_prescale = 8'd0;
    bp = bit_period();
    exp_data(9'h096, f, len);
    send(1'b1, 1'b0, 1'b0, 9'h096);
    check_frame(f, len, bp, "R9", 1'b0);

    // R10: requests during a frame are ignored
    cfg_div = 8'd1;
    bp = bit_period();
    exp_data(9'h055, f, len);
    send(1'b1, 1'b0, 1'b0, 9'h055);
    wait_to(3 * bp + 5);
    tx_data = 9'h0AA; tx_req = 1'b1; brk_req = 1'b1; idle_req = 1'b1;
    @(negedge clk); pos++;
    tx_req = 1'b0; brk_req = 1'b0; idle_req = 1'b0;
    check_frame(f, len, bp, "R10", 1'b0);
    begin
      bit quiet;
      quiet = 1'b1;
      for (int c = 0; c < 3 * bp; c++) begin
        @(negedge clk);
        if (busy !== 1'b0 || txd !== 1'b1) quiet = 1'b0;
      end
      chk(quiet, "R10", "no frame after ignored request", int'(quiet), 1);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule